// File: doc/BRIEF.md
# Pairwise Dependence and Parallelism Checker

This block decides which tasks in a small group may run at the same time. Each of K tasks is described by two bitmasks over N shared resources, such as registers or memory words. One mask lists the resources the task reads and the other lists the resources it writes. A lower task index means the task comes earlier in program order. For every pair of tasks the block tests whether one task writes what the other reads, and whether both write the same resource. It records which kinds of dependence it finds. It then builds a symmetric compatibility matrix and one flag that says whether the whole group is free of conflicts.

A start pulse captures all descriptors into the block. The block then visits one pair per clock, in a fixed order. After the last pair it raises a one-cycle done pulse. The results stay unchanged until the next accepted start. A start that arrives while the block is busy is ignored. Pairs are never chained: if A is compatible with B and B is compatible with C, that says nothing about A with C.

Top module: `dep_checker`

## Requirements
- R1: For tasks i<j, the flow bit (bit 2 of the pair's 3-bit kind field) is set exactly when the write mask of task i overlaps the read mask of task j. Pair p occupies dep_kinds[3p+2:3p]. Pairs are numbered in the order (0,1),(0,2)…(0,K-1),(1,2)…, so p = i·K − i(i+1)/2 + (j−i−1).
- R2: For tasks i<j, the anti bit (bit 1 of the kind field) is set exactly when the write mask of task j overlaps the read mask of task i.
- R3: The output bit (bit 0 of the kind field) is set exactly when the two write masks overlap. All three bits may be set for the same pair.
- R4: A pair is compatible exactly when all three of its kind bits are clear. Read masks that overlap but have no write involved never make a pair incompatible.
- R5: The compatibility matrix places the entry for (i,j) at bit i·K+j. It is symmetric, and its diagonal bits read 1 after a completed run.
- R6: group_ok is the AND of the compatibility of all distinct pairs. It is cleared whenever any single pair conflicts, even when every other pair is compatible.
- R7: done is high for one cycle. It rises exactly K(K−1)/2 clock cycles after the edge that accepts start. All results hold their values until the next accepted start.
- R8: A start pulse that arrives while busy is high has no effect. The run in progress finishes on its original schedule with the descriptors captured at the start, and no extra done pulse follows.
- R9: Synchronous active-high reset clears busy, done, group_ok, the matrix and the kind fields. A run that was in progress is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Capture the descriptors and begin a run (only accepted when idle) |
| rd_sets | input | K·N | Read masks; task t at bits [t·N +: N] |
| wr_sets | input | K·N | Write masks; task t at bits [t·N +: N] |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| compat | output | K·K | Compatibility matrix, entry (i,j) at bit i·K+j |
| dep_kinds | output | 3·K(K−1)/2 | Per-pair {flow, anti, output} fields |
| group_ok | output | 1 | All distinct pairs are compatible |

## Verification
Every result is due at one moment: the cycle in which done is high, K(K−1)/2 cycles after the start edge. The bench counts that many rising edges from the accepting edge. It samples 1 ns after each edge, checks that done stays low until the last of those edges, and checks the matrix, the kind fields and group_ok in that cycle. One cycle later it checks that done has dropped while the results are still held. For the busy-start and mid-run-reset cases the bench keeps counting for a full run's length afterwards, to show that no stray done pulse appears.

// File: rtl/dep_chk_pkg.sv
package dep_chk_pkg;

    // Kind of dependence found for one ordered pair (earlier, later)
    typedef struct packed {
        logic flow;   // earlier writes what later reads
        logic anti;   // later writes what earlier reads
        logic outp;   // both write the same resource
    } dep_kind_t;

    function automatic int pair_count(input int k);
        return (k * (k - 1)) / 2;
    endfunction

endpackage

// File: rtl/dep_pair_eval.sv
module dep_pair_eval
    import dep_chk_pkg::*;
#(
    parameter int N = 10
) (
    input  logic [N-1:0] rd_early,
    input  logic [N-1:0] wr_early,
    input  logic [N-1:0] rd_late,
    input  logic [N-1:0] wr_late,
    output dep_kind_t    kind,
    output logic         pair_ok
);

    always_comb begin
        kind.flow = |(wr_early & rd_late);
        kind.anti = |(wr_late & rd_early);
        kind.outp = |(wr_early & wr_late);
        // shared reads deliberately not tested
        pair_ok   = ~(kind.flow | kind.anti | kind.outp);
    end

endmodule

// File: rtl/dep_pair_walker.sv
module dep_pair_walker #(
    parameter int K  = 5,
    parameter int IW = 3,
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          advance,
    output logic [IW-1:0] i_idx,
    output logic [IW-1:0] j_idx,
    output logic [PW-1:0] p_idx,
    output logic          last
);

    localparam int NP = (K * (K - 1)) / 2;

    typedef struct packed {
        logic [IW-1:0] i;
        logic [IW-1:0] j;
        logic [PW-1:0] p;
    } walk_t;

    walk_t w_d, w_q;

    always_comb begin
        w_d = w_q;
        if (load) begin
            w_d.i = '0;
            w_d.j = IW'(1);
            w_d.p = '0;
        end else if (advance) begin
            w_d.p = w_q.p + PW'(1);
            if (w_q.j == IW'(K - 1)) begin
                w_d.i = w_q.i + IW'(1);
                w_d.j = w_q.i + IW'(2);
            end else begin
                w_d.j = w_q.j + IW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            w_q.i <= '0;
            w_q.j <= IW'(1);
            w_q.p <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    assign i_idx = w_q.i;
    assign j_idx = w_q.j;
    assign p_idx = w_q.p;
    assign last  = (w_q.p == PW'(NP - 1));

    AST_EARLY_BEFORE_LATE: assert property (@(posedge clk) disable iff (rst)
        advance |-> (i_idx < j_idx) && (int'(j_idx) < K));   // R1
    AST_PAIR_STEP: assert property (@(posedge clk) disable iff (rst)
        (advance && !last && !load) |=> (p_idx == $past(p_idx) + PW'(1)));   // R8

endmodule

// File: rtl/dep_checker.sv
module dep_checker
    import dep_chk_pkg::*;
#(
    parameter int K = 5,
    parameter int N = 10
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                start,
    input  logic [K*N-1:0]                      rd_sets,
    input  logic [K*N-1:0]                      wr_sets,
    output logic                                busy,
    output logic                                done,
    output logic [K*K-1:0]                      compat,
    output logic [3*((K*(K-1))/2)-1:0]          dep_kinds,
    output logic                                group_ok
);

    localparam int NP = (K * (K - 1)) / 2;
    localparam int IW = (K > 2) ? $clog2(K) : 1;
    localparam int PW = (NP > 1) ? $clog2(NP) : 1;

    typedef struct packed {
        logic             busy;
        logic             done;
        logic             group;
        logic [K*N-1:0]   rd;
        logic [K*N-1:0]   wr;
        logic [K*K-1:0]   compat;
        logic [3*NP-1:0]  kinds;
    } state_t;

    state_t s_d, s_q;

    logic [IW-1:0] i_idx, j_idx;
    logic [PW-1:0] p_idx;
    logic          last;
    logic          accept;
    dep_kind_t     kind;
    logic          pair_ok;
    logic [N-1:0]  rd_e, wr_e, rd_l, wr_l;
    logic [K*K-1:0] diag;

    assign accept = start && !s_q.busy;

    dep_pair_walker #(.K(K), .IW(IW), .PW(PW)) u_walk (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .advance (s_q.busy),
        .i_idx   (i_idx),
        .j_idx   (j_idx),
        .p_idx   (p_idx),
        .last    (last)
    );

    always_comb begin
        rd_e = s_q.rd[int'(i_idx)*N +: N];
        wr_e = s_q.wr[int'(i_idx)*N +: N];
        rd_l = s_q.rd[int'(j_idx)*N +: N];
        wr_l = s_q.wr[int'(j_idx)*N +: N];
    end

    dep_pair_eval #(.N(N)) u_eval (
        .rd_early (rd_e),
        .wr_early (wr_e),
        .rd_late  (rd_l),
        .wr_late  (wr_l),
        .kind     (kind),
        .pair_ok  (pair_ok)
    );

    always_comb begin
        diag = '0;
        for (int t = 0; t < K; t++) begin
            diag[t*K + t] = 1'b1;
        end
    end

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (accept) begin
            s_d.busy   = 1'b1;
            s_d.rd     = rd_sets;
            s_d.wr     = wr_sets;
            s_d.compat = diag;
            s_d.kinds  = '0;
            s_d.group  = 1'b1;
        end else if (s_q.busy) begin
            s_d.compat[int'(i_idx)*K + int'(j_idx)] = pair_ok;
            s_d.compat[int'(j_idx)*K + int'(i_idx)] = pair_ok;
            s_d.kinds[int'(p_idx)*3 +: 3]           = kind;
            s_d.group                               = s_q.group & pair_ok;
            if (last) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy      = s_q.busy;
    assign done      = s_q.done;
    assign compat    = s_q.compat;
    assign dep_kinds = s_q.kinds;
    assign group_ok  = s_q.group;

    // ---------------- assertions ----------------
    int lat_q;
    always_ff @(posedge clk) begin
        if (rst)            lat_q <= 0;
        else if (accept)    lat_q <= 0;
        else if (s_q.busy)  lat_q <= lat_q + 1;
    end

    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        done |-> (lat_q == NP));   // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);   // R7
    AST_BUSY_START_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !last) |=> busy);   // R8
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!done && !busy && !group_ok && compat == '0 && dep_kinds == '0));   // R9

    logic [K*K-1:0] offdiag_mask;
    always_comb offdiag_mask = ~diag;

    AST_GROUP_AND: assert property (@(posedge clk) disable iff (rst)
        done |-> (group_ok == &(compat | ~offdiag_mask)));   // R6

    for (genvar a = 0; a < K; a++) begin : g_row
        AST_DIAG_ONE: assert property (@(posedge clk) disable iff (rst)
            done |-> compat[a*K + a]);   // R5
        for (genvar b = a + 1; b < K; b++) begin : g_col
            localparam int P = a*K - (a*(a+1))/2 + (b - a - 1);
            AST_SYMMETRIC: assert property (@(posedge clk) disable iff (rst)
                done |-> (compat[a*K + b] == compat[b*K + a]));   // R5
            AST_KIND_COMPAT: assert property (@(posedge clk) disable iff (rst)
                done |-> (compat[a*K + b] == ~|dep_kinds[P*3 +: 3]));   // R4
        end
    end

endmodule

// File: tb/sim_dep_checker.sv
`timescale 1ns/1ps
module sim_dep_checker;

    localparam int K  = 5;
    localparam int N  = 10;
    localparam int NP = (K * (K - 1)) / 2;
    localparam int NV = 7;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               start = 1'b0;
    logic [K*N-1:0]     rd_sets = '0;
    logic [K*N-1:0]     wr_sets = '0;
    logic               busy, done, group_ok;
    logic [K*K-1:0]     compat;
    logic [3*NP-1:0]    dep_kinds;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dep_checker #(.K(K), .N(N)) u0 (
        .clk(clk), .rst(rst), .start(start),
        .rd_sets(rd_sets), .wr_sets(wr_sets),
        .busy(busy), .done(done), .compat(compat),
        .dep_kinds(dep_kinds), .group_ok(group_ok)
    );

    // Task masks packed {t4,t3,t2,t1,t0}; bit 0 of each 10-bit mask = resource 0
    localparam logic [K*N-1:0] RD_TAB [NV] = '{
        {10'b0001010000, 10'b0110000000, 10'b0001000010, 10'b0001000100, 10'b0000011000},
        {10'b0000010000, 10'b0000001000, 10'b0000000100, 10'b0000000010, 10'b0000000001},
        {10'b0000000001, 10'b0000000001, 10'b0000000001, 10'b0000000001, 10'b0000000001},
        {10'b0000000000, 10'b0000000000, 10'b0000000000, 10'b0000000000, 10'b0000000000},
        {10'b0000000000, 10'b0000000000, 10'b0000000000, 10'b0000000000, 10'b0000000000},
        {10'b0000000000, 10'b0000000000, 10'b0000000001, 10'b0000000010, 10'b0000001000},
        {10'b0000000000, 10'b0000000000, 10'b0000000000, 10'b0000000100, 10'b0000000010}
    };
    localparam logic [K*N-1:0] WR_TAB [NV] = '{
        {10'b0000100000, 10'b0000000100, 10'b0000000001, 10'b0100000000, 10'b0000000100},
        {10'b1000000000, 10'b0100000000, 10'b0010000000, 10'b0001000000, 10'b0000100000},
        {10'b0000100000, 10'b0000010000, 10'b0000001000, 10'b0000000100, 10'b0000000010},
        {10'b1000000000, 10'b1000000000, 10'b1000000000, 10'b1000000000, 10'b1000000000},
        {10'b0000000000, 10'b0000000000, 10'b0000000000, 10'b0000000000, 10'b0000000000},
        {10'b0000001000, 10'b0000000000, 10'b0000000000, 10'b0000000000, 10'b0000000001},
        {10'b0000000000, 10'b0000000000, 10'b0000000000, 10'b0000000110, 10'b0000000100}
    };
    localparam logic GRP_TAB [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference: {flow, anti, output} from the requirements (i earlier than j)
    function automatic logic [2:0] model_kind(input logic [K*N-1:0] rd, input logic [K*N-1:0] wr,
                                              input int i, input int j);
        logic [N-1:0] ri = rd[i*N +: N];
        logic [N-1:0] wi = wr[i*N +: N];
        logic [N-1:0] rj = rd[j*N +: N];
        logic [N-1:0] wj = wr[j*N +: N];
        return {|(wi & rj), |(wj & ri), |(wi & wj)};
    endfunction

    task automatic check_results(input logic [K*N-1:0] rd, input logic [K*N-1:0] wr,
                                 input logic exp_grp, input string tag);
        logic all_ok = 1'b1;
        int p = 0;
        for (int i = 0; i < K; i++) begin
            chk(compat[i*K+i] == 1'b1, "R5", {tag, " diagonal"}, compat[i*K+i], 1);
            for (int j = i + 1; j < K; j++) begin
                logic [2:0] ek = model_kind(rd, wr, i, j);
                logic [2:0] ak = dep_kinds[p*3 +: 3];
                chk(ak[2] == ek[2], "R1", {tag, " flow bit"}, ak[2], ek[2]);
                chk(ak[1] == ek[1], "R2", {tag, " anti bit"}, ak[1], ek[1]);
                chk(ak[0] == ek[0], "R3", {tag, " output bit"}, ak[0], ek[0]);
                chk(compat[i*K+j] == ~|ek, "R4", {tag, " compat upper"}, compat[i*K+j], ~|ek);
                chk(compat[j*K+i] == ~|ek, "R5", {tag, " compat mirror"}, compat[j*K+i], ~|ek);
                all_ok &= ~|ek;
                p++;
            end
        end
        chk(group_ok == all_ok, "R6", {tag, " group vs pairs"}, group_ok, all_ok);
        chk(group_ok == exp_grp, "R6", {tag, " group vs table"}, group_ok, exp_grp);
    endtask

    // Drive start for one cycle; return after the accepting edge (+1ns)
    task automatic launch(input logic [K*N-1:0] rd, input logic [K*N-1:0] wr);
        @(negedge clk);
        rd_sets = rd;
        wr_sets = wr;
        start   = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
    endtask

    task automatic run_vec(input logic [K*N-1:0] rd, input logic [K*N-1:0] wr,
                           input logic exp_grp, input string tag);
        int early = 0;
        launch(rd, wr);
        for (int c = 1; c <= NP; c++) begin
            @(posedge clk);
            #1;
            if (c < NP && done) early++;
            if (c == NP) chk(done == 1'b1, "R7", {tag, " done at latency"}, done, 1);
        end
        chk(early == 0, "R7", {tag, " no early done"}, early, 0);
        check_results(rd, wr, exp_grp, tag);
        @(posedge clk);
        #1;
        chk(done == 1'b0, "R7", {tag, " done one cycle"}, done, 0);
        chk(group_ok == exp_grp, "R7", {tag, " group held"}, group_ok, exp_grp);
    endtask

    initial begin
        int stray;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R9: reset state
        chk(busy == 1'b0 && done == 1'b0, "R9", "reset busy/done", {busy, done}, 0);
        chk(compat == '0, "R9", "reset matrix", compat, 0);
        chk(dep_kinds == '0 && group_ok == 1'b0, "R9", "reset kinds/group", dep_kinds, 0);

        for (int v = 0; v < NV; v++) begin
            run_vec(RD_TAB[v], WR_TAB[v], GRP_TAB[v], $sformatf("vec%0d", v));
        end

        // R8: start while busy with different descriptors is ignored
        launch(RD_TAB[1], WR_TAB[1]);
        stray = 0;
        for (int c = 1; c <= NP; c++) begin
            if (c == 3) begin
                @(negedge clk);
                rd_sets = RD_TAB[3];
                wr_sets = WR_TAB[3];
                start   = 1'b1;
                @(posedge clk);
                #1 start = 1'b0;
            end else begin
                @(posedge clk);
                #1;
            end
            if (c < NP && done) stray++;
            if (c == NP) chk(done == 1'b1, "R8", "done on original schedule", done, 1);
        end
        check_results(RD_TAB[1], WR_TAB[1], 1'b1, "R8 busy-start");
        for (int c = 0; c < NP + 2; c++) begin
            @(posedge clk);
            #1;
            if (done || busy) stray++;
        end
        chk(stray == 0, "R8", "no extra run or done", stray, 0);

        // R9: reset in the middle of a run
        launch(RD_TAB[0], WR_TAB[0]);
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b1;
        @(posedge clk);
        #1 rst = 1'b0;
        chk(busy == 1'b0 && done == 1'b0, "R9", "mid-run reset busy/done", {busy, done}, 0);
        chk(compat == '0 && group_ok == 1'b0, "R9", "mid-run reset results", compat, 0);
        stray = 0;
        for (int c = 0; c < NP + 2; c++) begin
            @(posedge clk);
            #1;
            if (done) stray++;
        end
        chk(stray == 0, "R9", "abandoned run gives no done", stray, 0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule